// File: doc/BRIEF.md
# Dual-Rate Machine-Cycle Clock Enable Generator

This block turns the oscillator clock into clock-enable strobes: one for the CPU phase generator and one for each of seven peripherals (timer 0, timer 1, timer 2, UART, PCA, watchdog, and a shared CAN/ADC strobe). A two-stage prescaler makes a divided-by-two oscillator level. In standard rate a strobe is high in one oscillator cycle out of two, so a phase generator that counts 6 phases per machine cycle sees 12 oscillator periods per cycle. In fast rate the CPU strobe is high on every oscillator cycle, which gives 6 periods per cycle. Each peripheral can stay at the standard rate while the CPU runs fast.

Software writes an 8-bit rate register at any time. The block copies the register into its working rate setting only on a clock edge where the divided oscillator rises, so a rate change never cuts a divided period short. A configuration pin sampled during reset can make the block leave reset in fast rate. The idle input stops only the CPU strobe. The power-down input stops every strobe and freezes the prescaler and the working rate. All pins are plain control levels with no flow control, because nothing streams through the block.

Top module: `clkgen_dual_rate`

## Requirements
- R1: During reset the rate register reads {7'b0, boot_fast}. A write (cfg_we high at a clock edge) can be read back on cfg_rdata after that edge. Bit 0 of the register is the global fast-rate bit. Bit k+1 (k = 0..6) is the keep-standard bit of periph_stb[k], in this order: T0, T1, T2, UART, PCA, watchdog, CAN/ADC.
- R2: osc_div is 0 during reset. After reset it inverts on every clock edge while pdown_req is low.
- R3: While the working fast bit is 0, cpu_stb is high in exactly half of the cycles, which is 4 of any 8 consecutive cycles.
- R4: While the working fast bit is 1 and neither idle_req nor pdown_req is high, cpu_stb is high in every cycle.
- R5: While the working fast bit is 1, periph_stb[k] is high in every cycle if register bit k+1 is 0, and in 4 of any 8 consecutive cycles if that bit is 1.
- R6: While the working fast bit is 0, register bits 7..1 have no effect: every periph_stb bit is high in 4 of any 8 consecutive cycles, and all bits are equal.
- R7: The working rate setting (shown on fast_active) changes only on a clock edge after which osc_div is 1. A written value takes effect within 2 clock edges after the write edge.
- R8: With boot_fast high during reset, fast_active is 1 out of reset and cpu_stb is high in every cycle.
- R9: While idle_req is high, cpu_stb is 0. The peripheral strobes keep their rate.
- R10: While pdown_req is high, every strobe is 0 even if idle_req is also high. osc_div and fast_active hold their values. A register write is still accepted, but it is applied only after pdown_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_fast | input | 1 | Configuration bit sampled in reset: 1 starts in fast rate |
| cfg_we | input | 1 | Rate register write enable |
| cfg_wdata | input | 8 | Rate register write data |
| cfg_rdata | output | 8 | Rate register software view |
| idle_req | input | 1 | Freezes the CPU strobe only |
| pdown_req | input | 1 | Freezes all strobes, the prescaler and the working rate |
| cpu_stb | output | 1 | CPU phase enable |
| periph_stb | output | 7 | Peripheral enables: T0, T1, T2, UART, PCA, watchdog, CAN/ADC |
| osc_div | output | 1 | Oscillator divided by two |
| fast_active | output | 1 | Working global fast-rate bit |

## Verification
The bench writes all 256 register values in turn. For each value it counts, over an 8-cycle window, how often the CPU strobe and each peripheral strobe are high. This separates the 8-of-8 rate from the 4-of-8 rate for every peripheral bit, with the global bit both set and cleared. On every change of fast_active the bench checks the divided-oscillator level, to catch a rate switch that lands off a divider rise. Writes are also issued on both divider phases, which bounds the time until a write takes effect. Separate runs cover idle, power-down, both together, a write made during power-down, and reset with the fast-start pin both set and cleared.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int unsigned N_PERIPH = 7;
  localparam int unsigned CTRL_W   = N_PERIPH + 1;

  // Peripheral strobe index; register bit is index + 1
  typedef enum logic [2:0] {
    PER_T0, PER_T1, PER_T2, PER_UART, PER_PCA, PER_WDOG, PER_CANADC
  } periph_e;

  typedef struct packed {
    logic [N_PERIPH-1:0] keep_std;
    logic                fast;
  } rate_cfg_t;
endpackage

// File: rtl/clkgen_prescaler.sv
module clkgen_prescaler #(
  parameter int unsigned STD_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  output logic div_level,
  output logic rise_next,
  output logic slow_stb
);
  localparam int unsigned CW   = (STD_DIV > 2) ? $clog2(STD_DIV) : 1;
  localparam int unsigned HALF = STD_DIV / 2;
  localparam logic [CW-1:0] LAST      = CW'(STD_DIV - 1);
  localparam logic [CW-1:0] PRE_RISE  = CW'(HALF - 1);
  localparam logic [CW-1:0] HIGH_FROM = CW'(HALF);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!freeze)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign div_level = (cnt_q >= HIGH_FROM);
  assign rise_next = (cnt_q == PRE_RISE);
  assign slow_stb  = (cnt_q == LAST);

  generate
    if (STD_DIV == 2) begin : g_half_checks
      p_div_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> div_level != $past(div_level));
    end
  endgenerate

  p_div_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(div_level));
endmodule

// File: rtl/clkgen_rate_ctrl.sv
module clkgen_rate_ctrl
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_fast,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              apply_ok,
  input  logic              div_level,
  output logic [CTRL_W-1:0] sw_q,
  output rate_cfg_t         work_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_q <= {{N_PERIPH{1'b0}}, boot_fast};
    else if (wr_en)
      sw_q <= wr_data;
  end

  // Working copy follows the software view only at a divider rise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q.keep_std <= '0;
      work_q.fast     <= boot_fast;
    end else if (apply_ok) begin
      work_q <= rate_cfg_t'(sw_q);
    end
  end

  p_apply_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(work_q) |-> div_level);

  p_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sw_q == $past(wr_data));
endmodule

// File: rtl/clkgen_strobes.sv
module clkgen_strobes #(
  parameter int unsigned NP = 7
) (
  input  logic          fast,
  input  logic [NP-1:0] keep_std,
  input  logic          slow_stb,
  input  logic          idle,
  input  logic          pdown,
  output logic          cpu_stb,
  output logic [NP-1:0] per_stb
);
  assign cpu_stb = ~pdown & ~idle & (fast | slow_stb);

  generate
    for (genvar i = 0; i < NP; i++) begin : g_per
      logic runs_fast;
      assign runs_fast  = fast & ~keep_std[i];
      assign per_stb[i] = ~pdown & (runs_fast | slow_stb);
    end
  endgenerate
endmodule

// File: rtl/clkgen_dual_rate.sv
module clkgen_dual_rate
  import clkgen_pkg::*;
#(
  parameter int unsigned STD_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_fast,
  input  logic                cfg_we,
  input  logic [CTRL_W-1:0]   cfg_wdata,
  output logic [CTRL_W-1:0]   cfg_rdata,
  input  logic                idle_req,
  input  logic                pdown_req,
  output logic                cpu_stb,
  output logic [N_PERIPH-1:0] periph_stb,
  output logic                osc_div,
  output logic                fast_active
);
  logic      rise_next;
  logic      slow_stb;
  rate_cfg_t work;

  clkgen_prescaler #(.STD_DIV(STD_DIV)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (pdown_req),
    .div_level (osc_div),
    .rise_next (rise_next),
    .slow_stb  (slow_stb)
  );

  clkgen_rate_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_fast (boot_fast),
    .wr_en     (cfg_we),
    .wr_data   (cfg_wdata),
    .apply_ok  (rise_next & ~pdown_req),
    .div_level (osc_div),
    .sw_q      (cfg_rdata),
    .work_q    (work)
  );

  clkgen_strobes #(.NP(N_PERIPH)) u_stb (
    .fast     (work.fast),
    .keep_std (work.keep_std),
    .slow_stb (slow_stb),
    .idle     (idle_req),
    .pdown    (pdown_req),
    .cpu_stb  (cpu_stb),
    .per_stb  (periph_stb)
  );

  assign fast_active = work.fast;

  p_pdown_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_req |-> (!cpu_stb && periph_stb == '0));

  p_pdown_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_req |=> $stable(fast_active));

  p_idle_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |-> !cpu_stb);

  p_fast_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_active && !idle_req && !pdown_req) |-> cpu_stb);

  p_std_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_active && !pdown_req) |-> (periph_stb == '0 || periph_stb == '1));

  p_std_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !fast_active && !pdown_req && $past(!fast_active && !pdown_req))
      |-> periph_stb[0] != $past(periph_stb[0]));
endmodule

// File: tb/clkgen_dual_rate_test.sv
`timescale 1ns/1ps
module clkgen_dual_rate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_fast = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       idle_req = 1'b0;
  logic       pdown_req = 1'b0;
  logic       cpu_stb;
  logic [6:0] periph_stb;
  logic       osc_div;
  logic       fast_active;

  int  checks = 0;
  int  errors = 0;
  logic prev_fast = 1'b0;
  bit  track = 1'b0;

  always #2 clk = ~clk;

  clkgen_dual_rate uut (
    .clk(clk), .rst_n(rst_n), .boot_fast(boot_fast), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .idle_req(idle_req),
    .pdown_req(pdown_req), .cpu_stb(cpu_stb), .periph_stb(periph_stb),
    .osc_div(osc_div), .fast_active(fast_active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock; sample 2 ns after the edge; R7 alignment on every mode change
  task automatic cyc();
    @(posedge clk);
    #2;
    if (track && fast_active !== prev_fast)
      chk(osc_div === 1'b1, "R7", "rate change off divider rise", int'(osc_div), 1);
    prev_fast = fast_active;
  endtask

  task automatic write_reg(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic window(output int cpu_n, output int per_n[7], output int tog_n);
    logic last_div;
    cpu_n = 0;
    tog_n = 0;
    for (int k = 0; k < 7; k++) per_n[k] = 0;
    last_div = osc_div;
    for (int c = 0; c < 8; c++) begin
      cyc();
      if (cpu_stb) cpu_n++;
      for (int k = 0; k < 7; k++) if (periph_stb[k]) per_n[k]++;
      if (osc_div !== last_div) tog_n++;
      last_div = osc_div;
    end
  endtask

  task automatic do_reset(input logic bf);
    track = 1'b0;
    rst_n = 1'b0;
    boot_fast = bf;
    cfg_we = 1'b0;
    idle_req = 1'b0;
    pdown_req = 1'b0;
    repeat (3) cyc();
    chk(cfg_rdata == {7'b0, bf}, "R1", "reset register value", cfg_rdata, int'(bf));
    chk(osc_div == 1'b0, "R2", "divider in reset", osc_div, 0);
    chk(fast_active == bf, "R8", "reset rate", fast_active, int'(bf));
    rst_n = 1'b1;
    prev_fast = fast_active;
    track = 1'b1;
  endtask

  initial begin : main
    int cpu_n, tog_n, n;
    int per_n[7];

    do_reset(1'b0);
    chk(cpu_stb == 1'b0, "R3", "cpu strobe in reset", cpu_stb, 0);
    window(cpu_n, per_n, tog_n);
    chk(tog_n == 8, "R2", "divider toggles per 8 cycles", tog_n, 8);
    chk(cpu_n == 4, "R3", "cpu strobes after reset", cpu_n, 4);

    // Full sweep of the rate register
    for (int v = 0; v < 256; v++) begin
      logic [7:0] val;
      val = v[7:0];
      write_reg(val);
      chk(cfg_rdata == val, "R1", "readback", cfg_rdata, v);
      repeat (4) cyc();
      window(cpu_n, per_n, tog_n);
      if (val[0]) chk(cpu_n == 8, "R4", "fast cpu strobes", cpu_n, 8);
      else        chk(cpu_n == 4, "R3", "standard cpu strobes", cpu_n, 4);
      for (int k = 0; k < 7; k++) begin
        int e;
        e = (val[0] && !val[k+1]) ? 8 : 4;
        if (val[0]) chk(per_n[k] == e, "R5", $sformatf("periph %0d strobes", k), per_n[k], e);
        else        chk(per_n[k] == e, "R6", $sformatf("periph %0d ignored bit", k), per_n[k], e);
      end
      if (v == 0) chk(tog_n == 8, "R2", "divider toggles in sweep", tog_n, 8);
    end

    // Write on both divider phases: applied within 2 edges
    for (int ph = 0; ph < 2; ph++) begin
      write_reg(8'h00);
      repeat (4 + ph) cyc();
      write_reg(8'h01);
      n = 0;
      while (!fast_active && n < 6) begin
        cyc();
        n++;
      end
      chk(fast_active && n <= 2, "R7", $sformatf("apply latency phase %0d", ph), n, 2);
    end

    // Idle in fast and standard rate
    write_reg(8'h01);
    repeat (4) cyc();
    idle_req = 1'b1;
    window(cpu_n, per_n, tog_n);
    chk(cpu_n == 0, "R9", "idle fast cpu", cpu_n, 0);
    chk(per_n[0] == 8 && per_n[6] == 8, "R9", "idle fast periph", per_n[6], 8);
    write_reg(8'h00);
    repeat (4) cyc();
    window(cpu_n, per_n, tog_n);
    chk(cpu_n == 0, "R9", "idle standard cpu", cpu_n, 0);
    chk(per_n[3] == 4, "R9", "idle standard periph", per_n[3], 4);
    idle_req = 1'b0;

    // Power-down with a pending write and idle together
    write_reg(8'h01);
    repeat (4) cyc();
    pdown_req = 1'b1;
    cyc();
    write_reg(8'h00);
    chk(cfg_rdata == 8'h00, "R10", "write accepted in power-down", cfg_rdata, 0);
    idle_req = 1'b1;
    window(cpu_n, per_n, tog_n);
    n = 0;
    for (int k = 0; k < 7; k++) n += per_n[k];
    chk(cpu_n == 0, "R10", "power-down cpu", cpu_n, 0);
    chk(n == 0, "R10", "power-down periph", n, 0);
    chk(tog_n == 0, "R10", "divider frozen", tog_n, 0);
    chk(fast_active == 1'b1, "R10", "rate frozen", fast_active, 1);
    pdown_req = 1'b0;
    idle_req = 1'b0;
    repeat (4) cyc();
    chk(fast_active == 1'b0, "R10", "pending write applied after resume", fast_active, 0);

    // Fast start from reset
    do_reset(1'b1);
    window(cpu_n, per_n, tog_n);
    chk(cpu_n == 8, "R8", "fast start cpu strobes", cpu_n, 8);
    chk(per_n[2] == 8, "R8", "fast start periph strobes", per_n[2], 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule